// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between the clock dividers and the output drivers of a clock generator. It decides which CPU and PCI clocks reach the pins. It also makes sure that every start or stop of a clock happens without glitches. Power management can halt one gated CPU clock and a group of gated PCI clocks through two active-low stop requests. A configuration mask can turn off any output one by one. A free-running CPU clock and a free-running PCI clock ignore the stop requests and follow only their mask bits.

A mode strap is captured once after reset. In one mode, the two shared pins carry stop requests and the two extra PCI clocks stay low. In the other mode, which is the default, the shared pins carry the two extra PCI clocks and the stop requests have no effect. All outputs stay low during a settling interval after reset.

The source clocks are modelled as digital inputs sampled by a faster reference clock `clk_i`. A change of enable is first armed on a rising edge of the free PCI source. It is then applied at the next falling edge of the source of the affected output. A gated output is the AND of its source and an enable that changes only while the source is low.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Every output stays low for SETTLE_CYCLES cycles of clk_i after reset is released, whatever the mask, stop and source inputs are.
- R2: strap_mode_i is captured in the first clk_i cycle after reset. Later changes to it have no effect until the next reset.
- R3: With mode 1 captured, the stop inputs have no effect, and each pci_ext_o clock runs when its mask bit is set.
- R4: With mode 0 captured, pci_ext_o stays low and the stop inputs are honoured.
- R5: In mode 0, cpu_stop_ni=0 holds cpu_gated_o low, and cpu_stop_ni=1 lets it follow cpu_src_i.
- R6: In mode 0, pci_stop_ni=0 holds every pci_gated_o bit low, and pci_stop_ni=1 lets them follow pci_src_i.
- R7: cpu_free_o and pci_free_o follow their sources under all four combinations of the stop inputs, provided their mask bits are set.
- R8: Mask layout en_mask_i: bit 0 cpu_free_o, bit 1 cpu_gated_o, bit 2 pci_free_o, bits 3 to 3+NUM_PCI-1 pci_gated_o, and the next NUM_EXT bits pci_ext_o. An output runs only when its bit is 1 and no active stop request blocks it. A cleared bit holds the output low.
- R9: An output's enable changes only at a falling edge of its own source that follows a rising edge of pci_src_i. Every high pulse therefore has the full length of the source high phase, and a stopped output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_mode_i | input | 1 | Mode strap, captured once after reset |
| cpu_src_i | input | 1 | Divided CPU source clock |
| pci_src_i | input | 1 | Divided PCI source clock |
| cpu_stop_ni | input | 1 | Active-low CPU stop request (mode 0 only) |
| pci_stop_ni | input | 1 | Active-low PCI stop request (mode 0 only) |
| en_mask_i | input | 3+NUM_PCI+NUM_EXT | Per-output enable mask |
| cpu_free_o | output | 1 | Free-running CPU clock |
| cpu_gated_o | output | 1 | Stoppable CPU clock |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_gated_o | output | NUM_PCI | Stoppable PCI clocks |
| pci_ext_o | output | NUM_EXT | Extra PCI clocks on the shared pins |

## Verification
The assertions assume two things about the sources. First, cpu_src_i and pci_src_i change only between rising edges of clk_i. Second, each high or low phase lasts at least two clk_i cycles. Only under these conditions is an enable change that is sampled low also free of overlap with a high phase. The bench meets these conditions by toggling both sources on the falling edge of clk_i, with 2/2 and 4/4 phase lengths. It holds strap_mode_i steady across each reset and changes the mask and stop inputs only after the monitor has finished checking the previous setting.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic {
    MODE_STOP_PINS = 1'b0,
    MODE_EXTRA_CLK = 1'b1
  } pin_mode_e;

  localparam int unsigned IDX_CPU_FREE  = 0;
  localparam int unsigned IDX_CPU_GATED = 1;
  localparam int unsigned IDX_PCI_FREE  = 2;
  localparam int unsigned IDX_PCI_BASE  = 3;
endpackage

// File: rtl/csc_strap_latch.sv
module csc_strap_latch
  import clk_stop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strap_i,
  output pin_mode_e mode_o,
  output logic      loaded_o
);
  pin_mode_e mode_q;
  logic      loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_EXTRA_CLK;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      mode_q   <= pin_mode_e'(strap_i);
      loaded_q <= 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/csc_settle_timer.sv
module csc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == LIMIT);
endmodule

// File: rtl/csc_sync2.sv
module csc_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  // reset to "no stop" so outputs are not requested off by the reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic src_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      if (src_q && !src_i) en_q <= req_i;  // load only while source is low
    end
  end

  assign en_o   = en_q;
  assign gclk_o = src_i & en_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int unsigned NUM_PCI       = 4,
  parameter int unsigned NUM_EXT       = 2,
  parameter int unsigned SETTLE_CYCLES = 32,
  localparam int unsigned EN_W         = IDX_PCI_BASE + NUM_PCI + NUM_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_mode_i,
  input  logic               cpu_src_i,
  input  logic               pci_src_i,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic [EN_W-1:0]    en_mask_i,
  output logic               cpu_free_o,
  output logic               cpu_gated_o,
  output logic               pci_free_o,
  output logic [NUM_PCI-1:0] pci_gated_o,
  output logic [NUM_EXT-1:0] pci_ext_o
);
  localparam int unsigned EXT_BASE = IDX_PCI_BASE + NUM_PCI;

  pin_mode_e       mode;
  logic            loaded;
  logic            settled;
  logic [1:0]      stop_n_sync;
  logic            cpu_run, pci_run;
  logic            pci_q, pci_rise;
  logic [EN_W-1:0] allow, req_q, src_vec, en_vec, gclk;

  csc_strap_latch u_strap (
    .clk_i, .rst_ni, .strap_i(strap_mode_i), .mode_o(mode), .loaded_o(loaded)
  );

  csc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i, .rst_ni, .settled_o(settled)
  );

  csc_sync2 #(.WIDTH(2)) u_sync (
    .clk_i, .rst_ni, .d_i({cpu_stop_ni, pci_stop_ni}), .q_o(stop_n_sync)
  );

  // stop pins only count when the strap selected them as inputs
  assign cpu_run = (mode == MODE_EXTRA_CLK) || stop_n_sync[1];
  assign pci_run = (mode == MODE_EXTRA_CLK) || stop_n_sync[0];

  always_comb begin
    allow = '0;
    for (int i = 0; i < int'(EN_W); i++) begin
      if (i == IDX_CPU_GATED)     allow[i] = cpu_run;
      else if (i >= EXT_BASE)     allow[i] = (mode == MODE_EXTRA_CLK);
      else if (i >= IDX_PCI_BASE) allow[i] = pci_run;
      else                        allow[i] = 1'b1;
    end
    allow = allow & en_mask_i & {EN_W{settled && loaded}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_q <= 1'b0;
      req_q <= '0;
    end else begin
      pci_q <= pci_src_i;
      if (pci_rise) req_q <= allow;
    end
  end

  assign pci_rise = pci_src_i && !pci_q;

  for (genvar g = 0; g < EN_W; g++) begin : g_gate
    if (g < IDX_PCI_FREE) begin : g_cpu
      assign src_vec[g] = cpu_src_i;
    end else begin : g_pci
      assign src_vec[g] = pci_src_i;
    end
    csc_gate_cell u_cell (
      .clk_i, .rst_ni, .src_i(src_vec[g]), .req_i(req_q[g]),
      .en_o(en_vec[g]), .gclk_o(gclk[g])
    );
  end

  assign cpu_free_o  = gclk[IDX_CPU_FREE];
  assign cpu_gated_o = gclk[IDX_CPU_GATED];
  assign pci_free_o  = gclk[IDX_PCI_FREE];
  assign pci_gated_o = gclk[IDX_PCI_BASE +: NUM_PCI];
  assign pci_ext_o   = gclk[EXT_BASE +: NUM_EXT];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int unsigned EN_W    = 9,
  parameter int unsigned NUM_EXT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               settled,
  input logic               loaded,
  input logic               mode,
  input logic [EN_W-1:0]    src_vec,
  input logic [EN_W-1:0]    en_vec,
  input logic [EN_W-1:0]    gclk,
  input logic               cpu_src_i,
  input logic               pci_src_i,
  input logic               cpu_gated_o,
  input logic               pci_free_o,
  input logic [NUM_EXT-1:0] pci_ext_o
);
  assert_quiet_until_settled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settled |-> gclk == '0);

  assert_strap_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && $past(loaded)) |-> $stable(mode));

  assert_ext_low_in_stop_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && !mode) |-> pci_ext_o == '0);

  assert_cpu_no_short_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_gated_o) |-> $fell(cpu_src_i));

  assert_pci_free_rise_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_free_o) |-> $rose(pci_src_i));

  assert_enable_moves_when_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_vec ^ $past(en_vec)) & src_vec) == '0);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.EN_W(EN_W), .NUM_EXT(NUM_EXT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .settled(settled), .loaded(loaded), .mode(mode),
  .src_vec(src_vec), .en_vec(en_vec), .gclk(gclk), .cpu_src_i(cpu_src_i),
  .pci_src_i(pci_src_i), .cpu_gated_o(cpu_gated_o), .pci_free_o(pci_free_o),
  .pci_ext_o(pci_ext_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
  localparam int NUM_PCI = 4;
  localparam int NUM_EXT = 2;
  localparam int SETTLE  = 32;
  localparam int EN_W    = 3 + NUM_PCI + NUM_EXT;

  typedef struct {
    logic [EN_W-1:0] exp;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strap = 1'b1;
  logic cpu_src = 1'b0, pci_src = 1'b0;
  logic cstop_n = 1'b1, pstop_n = 1'b1;
  logic [EN_W-1:0] mask = '0;
  logic cpu_free, cpu_gated, pci_free;
  logic [NUM_PCI-1:0] pci_gated;
  logic [NUM_EXT-1:0] pci_ext;
  logic [EN_W-1:0] outs;
  int unsigned cyc = 0;
  int total = 0, fails = 0;
  item_t q[$];
  logic mon_busy = 1'b0;
  logic pulse_on = 1'b0;

  always #4 clk = ~clk;

  clk_stop_ctrl #(.NUM_PCI(NUM_PCI), .NUM_EXT(NUM_EXT), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .strap_mode_i(strap), .cpu_src_i(cpu_src),
    .pci_src_i(pci_src), .cpu_stop_ni(cstop_n), .pci_stop_ni(pstop_n),
    .en_mask_i(mask), .cpu_free_o(cpu_free), .cpu_gated_o(cpu_gated),
    .pci_free_o(pci_free), .pci_gated_o(pci_gated), .pci_ext_o(pci_ext)
  );

  assign outs = {pci_ext, pci_gated, pci_free, cpu_gated, cpu_free};

  // sources: cpu 2 high / 2 low, pci 4 high / 4 low, changed away from rising edge
  initial forever begin
    @(negedge clk);
    cyc++;
    cpu_src = cyc[1];
    pci_src = cyc[2];
  end

  function automatic logic src_of(int i);
    return (i < 2) ? cpu_src : pci_src;
  endfunction

  // expected running set from R3..R8
  function automatic logic [EN_W-1:0] exp_of(logic [EN_W-1:0] m, logic c, logic p, logic md);
    logic [EN_W-1:0] e;
    e = m;
    if (!md) begin
      if (!c) e[1] = 1'b0;
      if (!p) e[3 +: NUM_PCI] = '0;
      e[3+NUM_PCI +: NUM_EXT] = '0;
    end
    return e;
  endfunction

  task automatic check(logic ok, string req, logic [EN_W-1:0] act, logic [EN_W-1:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic do_reset(logic md);
    rst_ni = 1'b0;
    strap  = md;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic drive(logic [EN_W-1:0] m, logic c, logic p, logic md, string tag);
    item_t it;
    mask = m; cstop_n = c; pstop_n = p;
    repeat (40) @(posedge clk);
    it.exp = exp_of(m, c, p, md);
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    wait (mon_busy == 1'b0);
  endtask

  // monitor: compare outputs to expected for two full pci periods
  initial forever begin
    item_t it;
    logic ok;
    logic [EN_W-1:0] want, bad_a, bad_e;
    wait (q.size() != 0);
    mon_busy = 1'b1;
    it = q.pop_front();
    ok = 1'b1; bad_a = '0; bad_e = '0;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #2;
      for (int i = 0; i < EN_W; i++) want[i] = it.exp[i] & src_of(i);
      if (outs !== want && ok) begin
        ok = 1'b0; bad_a = outs; bad_e = want;
      end
    end
    check(ok, it.tag, bad_a, bad_e);
    mon_busy = 1'b0;
  end

  // R9: every observed high pulse lasts a full source high phase
  initial begin
    int run [EN_W];
    foreach (run[i]) run[i] = 0;
    forever begin
      @(posedge clk); #2;
      if (!pulse_on || !rst_ni) begin
        foreach (run[i]) run[i] = 0;
      end else begin
        for (int i = 0; i < EN_W; i++) begin
          if (outs[i] === 1'b1) run[i]++;
          else if (run[i] > 0) begin
            check(run[i] == ((i < 2) ? 2 : 4), "R9 pulse width",
                  EN_W'(run[i]), EN_W'((i < 2) ? 2 : 4));
            run[i] = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic quiet;
    logic [EN_W-1:0] seen;
    // R1: outputs low during settling, everything requested on
    mask = '1;
    do_reset(1'b1);
    quiet = 1'b1; seen = '0;
    for (int k = 0; k < SETTLE - 2; k++) begin
      @(posedge clk); #2;
      seen |= outs;
      if (outs !== '0) quiet = 1'b0;
    end
    check(quiet, "R1 settle", seen, '0);
    pulse_on = 1'b1;

    // mode 1 captured
    drive('1, 1'b1, 1'b1, 1'b1, "R3 R8 all on");
    drive('1, 1'b0, 1'b0, 1'b1, "R3 stops ignored");
    drive('1, 1'b0, 1'b1, 1'b1, "R3 cpu stop ignored");
    drive(9'h0AA, 1'b1, 1'b1, 1'b1, "R8 mask 0AA");
    drive(9'h155, 1'b0, 1'b0, 1'b1, "R8 mask 155");
    drive('0, 1'b1, 1'b1, 1'b1, "R8 mask clear");

    // mode 0 captured, strap moved after capture (R2)
    pulse_on = 1'b0;
    mask = '1;
    do_reset(1'b0);
    repeat (2) @(posedge clk);
    #1 strap = 1'b1;
    repeat (SETTLE) @(posedge clk);
    pulse_on = 1'b1;
    drive('1, 1'b1, 1'b1, 1'b0, "R2 R4 ext low");
    drive('1, 1'b0, 1'b1, 1'b0, "R5 cpu stop");
    drive('1, 1'b1, 1'b1, 1'b0, "R5 cpu restart");
    drive('1, 1'b1, 1'b0, 1'b0, "R6 pci stop");
    drive('1, 1'b0, 1'b0, 1'b0, "R7 both stopped");
    drive('1, 1'b1, 1'b1, 1'b0, "R6 R9 restart");
    drive(9'h1FA, 1'b1, 1'b0, 1'b0, "R8 mask with stop");
    drive(9'h105, 1'b0, 1'b1, 1'b0, "R7 free only");
    repeat (8) @(posedge clk);
    finish_run();
  end
endmodule